// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the architectural side of taking an exception in a simple in-order 32-bit processor. When the pipeline raises a one-cycle request with a fault kind code, the block takes the faulting instruction's PC and its successor PC. It also takes the current status, cause and register-set control words. From these it computes the new contents of those control words and of the exception PC register, and the address of the handler to fetch from next.

All results appear together, registered, in the cycle after the request edge. Each result has its own one-cycle write strobe, so the control register file commits only the words that actually change. A separate redirect strobe carries the handler address to the fetch unit. The block detects when the faulting instruction sits in a branch delay slot and rewinds the exception PC by one instruction. It moves to the exception register set only when the core was in normal mode with run-time vectors. The power-on fault kind only redirects to the boot vector and grants floating-point unit access. Two fault kinds are never serviced here and only raise a flag: the warm restart kind and the non-maskable kind.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0 and a request is ignored. After release, outputs stay 0 until a request is taken.
- R2: For a serviced fault (kind codes 0 to 13), `status_out` equals `status_in` with bit 1 (exception level) set to 1, even when it was already 1, and `status_we` pulses.
- R3: A serviced fault swaps register sets only when bit 1 and bit 22 (boot vectors) of `status_in` are both 0. In that case `srsctl_out` takes bits 9:6 from input bits 3:0, takes bits 3:0 from input bits 15:12, keeps every other bit, and `srsctl_we` pulses. Otherwise `srsctl_we` stays 0.
- R4: For a serviced fault, the instruction is in a delay slot when `npc` differs from `pc` + 4. `epc_out` is then `pc` − 4, or `pc` otherwise, and `epc_we` pulses.
- R5: For a serviced fault, `cause_out` equals `cause_in` with three changes: bits 6:2 hold the code below, bit 31 holds the delay-slot flag, and bits 29:28 are 0. `cause_we` pulses. Codes by kind: 0 interrupt→0, 1 syscall→8, 2 breakpoint→9, 3 reserved opcode→10, 4 coprocessor unusable→11, 5 overflow→12, 6 trap→13, 7 machine check→24, 11 TLB store to clean page→1. The kinds 8 address error, 9 TLB refill, 10 TLB invalid, 12 thread and 13 DSP disabled all give 0.
- R6: For a serviced fault, `redirect_pc` is the base plus an offset, and `redirect_valid` pulses. The base is 0x80000000 when `status_in` bit 22 is 0 and 0xBFC00200 when it is 1. The offset is 0x000 for the interrupt kind and 0x180 for every other serviced kind.
- R7: Kind 14 (power-on) gives `redirect_pc` = 0xBFC00000 with `redirect_valid`, and `status_out` = `status_in` with bit 29 set with `status_we`. The cause, EPC and register-set strobes stay 0.
- R8: Kind 15 (warm restart), kind 16 (non-maskable) and kinds 17 to 31 pulse `unsupported`. They raise no write strobe and no redirect.
- R9: Every strobe and `unsupported` is high only in the cycle after an edge with `exc_req` high. Each stays low after an edge without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_kind | input | 5 | Fault kind code |
| pc | input | 32 | PC of the faulting instruction |
| npc | input | 32 | PC that would have followed it |
| status_in | input | 32 | Current status word |
| cause_in | input | 32 | Current cause word |
| srsctl_in | input | 32 | Current register-set control word |
| status_out | output | 32 | New status word |
| status_we | output | 1 | Status write strobe |
| cause_out | output | 32 | New cause word |
| cause_we | output | 1 | Cause write strobe |
| epc_out | output | 32 | New exception PC |
| epc_we | output | 1 | Exception PC write strobe |
| srsctl_out | output | 32 | New register-set control word |
| srsctl_we | output | 1 | Register-set control write strobe |
| redirect_pc | output | 32 | Handler fetch address |
| redirect_valid | output | 1 | Fetch redirect strobe |
| unsupported | output | 1 | Unserviced fault kind flag |

## Verification
Random vectors mix `npc` = `pc` + 4 with arbitrary successors, which separates the sequential path from the delay-slot rewind in EPC and bit 31. Status words are drawn so that all four combinations of the exception-level and boot-vector bits occur. These combinations tell the register-set swap apart from its blocked cases, and the two vector bases apart. Every kind code from 0 to 31 appears, including undefined codes, so the serviced, power-on and unsupported paths each show up with the right strobe set. Idle cycles and requests held during reset show whether a strobe can appear without an accepted request.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int KIND_W = 5;
  localparam int CODE_W = 5;
  localparam int SET_W  = 4;

  // status word fields
  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int ST_CU1 = 29;
  // cause word fields
  localparam int CA_CODE_LO = 2;
  localparam int CA_CE_LO   = 28;
  localparam int CA_BD      = 31;
  // register-set control fields
  localparam int SRS_CUR_LO  = 0;
  localparam int SRS_PREV_LO = 6;
  localparam int SRS_EXC_LO  = 12;

  typedef enum logic [KIND_W-1:0] {
    FK_INTR     = 5'd0,
    FK_SYSCALL  = 5'd1,
    FK_BREAK    = 5'd2,
    FK_RESVD    = 5'd3,
    FK_COP_UNUS = 5'd4,
    FK_OVFL     = 5'd5,
    FK_TRAP     = 5'd6,
    FK_MCHECK   = 5'd7,
    FK_ADDR_ERR = 5'd8,
    FK_TLB_RFL  = 5'd9,
    FK_TLB_INV  = 5'd10,
    FK_TLB_MOD  = 5'd11,
    FK_THREAD   = 5'd12,
    FK_DSP_OFF  = 5'd13,
    FK_POWER_ON = 5'd14,
    FK_WARM_RST = 5'd15,
    FK_NMI      = 5'd16
  } fault_kind_e;

  typedef enum logic [1:0] {
    ACT_HANDLER = 2'd0,
    ACT_BOOT    = 2'd1,
    ACT_UNSUP   = 2'd2
  } fault_action_e;

  typedef struct packed {
    fault_action_e       action;
    logic [CODE_W-1:0]   exc_code;
    logic                general_off;
  } fault_info_t;
endpackage

// File: rtl/exc_fault_decode.sv
module exc_fault_decode
  import exc_entry_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output fault_info_t       info
);
  always_comb begin
    info.action      = ACT_HANDLER;
    info.exc_code    = '0;
    info.general_off = 1'b1;
    case (kind)
      FK_INTR:     info.general_off = 1'b0;
      FK_SYSCALL:  info.exc_code = CODE_W'(8);
      FK_BREAK:    info.exc_code = CODE_W'(9);
      FK_RESVD:    info.exc_code = CODE_W'(10);
      FK_COP_UNUS: info.exc_code = CODE_W'(11);
      FK_OVFL:     info.exc_code = CODE_W'(12);
      FK_TRAP:     info.exc_code = CODE_W'(13);
      FK_MCHECK:   info.exc_code = CODE_W'(24);
      FK_TLB_MOD:  info.exc_code = CODE_W'(1);
      FK_ADDR_ERR, FK_TLB_RFL, FK_TLB_INV, FK_THREAD, FK_DSP_OFF: ;
      FK_POWER_ON: begin
        info.action      = ACT_BOOT;
        info.general_off = 1'b0;
      end
      default: begin
        info.action      = ACT_UNSUP;
        info.general_off = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] RESET_VEC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] RUN_BASE     = 32'h8000_0000,
  parameter logic [XLEN-1:0] BOOT_BASE    = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] GENERAL_OFF  = 32'h0000_0180
) (
  input  fault_action_e   action,
  input  logic            general_off,
  input  logic            bev,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base   = bev ? BOOT_BASE : RUN_BASE;
    offset = general_off ? GENERAL_OFF : '0;
    target = (action == ACT_BOOT) ? RESET_VEC : (base + offset);
  end
endmodule

// File: rtl/exc_state_update.sv
module exc_state_update
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  fault_info_t     info,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] npc,
  input  logic [XLEN-1:0] status_in,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] srsctl_in,
  output logic [XLEN-1:0] status_nxt,
  output logic [XLEN-1:0] cause_nxt,
  output logic [XLEN-1:0] epc_nxt,
  output logic [XLEN-1:0] srsctl_nxt,
  output logic            status_wr,
  output logic            cause_wr,
  output logic            epc_wr,
  output logic            srsctl_wr,
  output logic            redirect,
  output logic            unsup
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic in_slot;
  logic swap_ok;
  logic serviced;
  logic boot;

  always_comb begin
    serviced = (info.action == ACT_HANDLER);
    boot     = (info.action == ACT_BOOT);
    unsup    = (info.action == ACT_UNSUP);
    in_slot  = (npc != (pc + STEP));
    swap_ok  = ~status_in[ST_EXL] & ~status_in[ST_BEV];

    status_nxt = status_in;
    if (serviced) status_nxt[ST_EXL] = 1'b1;
    if (boot)     status_nxt[ST_CU1] = 1'b1;

    cause_nxt = cause_in;
    cause_nxt[CA_CODE_LO +: CODE_W] = info.exc_code;
    cause_nxt[CA_CE_LO +: 2]        = 2'b00;
    cause_nxt[CA_BD]                = in_slot;

    epc_nxt = in_slot ? (pc - STEP) : pc;

    srsctl_nxt = srsctl_in;
    srsctl_nxt[SRS_PREV_LO +: SET_W] = srsctl_in[SRS_CUR_LO +: SET_W];
    srsctl_nxt[SRS_CUR_LO +: SET_W]  = srsctl_in[SRS_EXC_LO +: SET_W];

    status_wr = serviced | boot;
    cause_wr  = serviced;
    epc_wr    = serviced;
    srsctl_wr = serviced & swap_ok;
    redirect  = serviced | boot;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] RUN_BASE    = 32'h8000_0000,
  parameter logic [XLEN-1:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] GENERAL_OFF = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [KIND_W-1:0] exc_kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   npc,
  input  logic [XLEN-1:0]   status_in,
  input  logic [XLEN-1:0]   cause_in,
  input  logic [XLEN-1:0]   srsctl_in,
  output logic [XLEN-1:0]   status_out,
  output logic              status_we,
  output logic [XLEN-1:0]   cause_out,
  output logic              cause_we,
  output logic [XLEN-1:0]   epc_out,
  output logic              epc_we,
  output logic [XLEN-1:0]   srsctl_out,
  output logic              srsctl_we,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              redirect_valid,
  output logic              unsupported
);
  fault_info_t     info;
  logic [XLEN-1:0] status_nxt, cause_nxt, epc_nxt, srsctl_nxt, target_nxt;
  logic            status_wr, cause_wr, epc_wr, srsctl_wr, redirect_nxt, unsup_nxt;

  exc_fault_decode u_decode (
    .kind (exc_kind),
    .info (info)
  );

  exc_vector_sel #(
    .XLEN(XLEN), .RESET_VEC(RESET_VEC), .RUN_BASE(RUN_BASE),
    .BOOT_BASE(BOOT_BASE), .GENERAL_OFF(GENERAL_OFF)
  ) u_vector (
    .action      (info.action),
    .general_off (info.general_off),
    .bev         (status_in[ST_BEV]),
    .target      (target_nxt)
  );

  exc_state_update #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_update (
    .info       (info),
    .pc         (pc),
    .npc        (npc),
    .status_in  (status_in),
    .cause_in   (cause_in),
    .srsctl_in  (srsctl_in),
    .status_nxt (status_nxt),
    .cause_nxt  (cause_nxt),
    .epc_nxt    (epc_nxt),
    .srsctl_nxt (srsctl_nxt),
    .status_wr  (status_wr),
    .cause_wr   (cause_wr),
    .epc_wr     (epc_wr),
    .srsctl_wr  (srsctl_wr),
    .redirect   (redirect_nxt),
    .unsup      (unsup_nxt)
  );

  // strobes: one cycle after an accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_we      <= 1'b0;
      cause_we       <= 1'b0;
      epc_we         <= 1'b0;
      srsctl_we      <= 1'b0;
      redirect_valid <= 1'b0;
      unsupported    <= 1'b0;
    end else begin
      status_we      <= exc_req & status_wr;
      cause_we       <= exc_req & cause_wr;
      epc_we         <= exc_req & epc_wr;
      srsctl_we      <= exc_req & srsctl_wr;
      redirect_valid <= exc_req & redirect_nxt;
      unsupported    <= exc_req & unsup_nxt;
    end
  end

  // data words: loaded only on a request (clock enable)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_out  <= '0;
      cause_out   <= '0;
      epc_out     <= '0;
      srsctl_out  <= '0;
      redirect_pc <= '0;
    end else if (exc_req) begin
      status_out  <= status_nxt;
      cause_out   <= cause_nxt;
      epc_out     <= epc_nxt;
      srsctl_out  <= srsctl_nxt;
      redirect_pc <= target_nxt;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
  parameter int              INSN_BYTES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] npc,
  input logic [XLEN-1:0] status_in,
  input logic [XLEN-1:0] status_out,
  input logic            status_we,
  input logic [XLEN-1:0] cause_out,
  input logic            cause_we,
  input logic [XLEN-1:0] epc_out,
  input logic            epc_we,
  input logic            srsctl_we,
  input logic [XLEN-1:0] redirect_pc,
  input logic            redirect_valid,
  input logic            unsupported
);
  assert_exl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |-> status_out[1]);

  assert_swap_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    srsctl_we |-> (!$past(status_in[1]) && !$past(status_in[22])));

  assert_epc_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |-> (cause_out[31] == ($past(npc) != ($past(pc) + XLEN'(INSN_BYTES)))));

  assert_ce_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |-> (cause_out[29:28] == 2'b00));

  assert_boot_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !cause_we) |-> (redirect_pc == RESET_VEC && status_out[29]));

  assert_unsup_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> !(status_we || cause_we || epc_we || srsctl_we || redirect_valid));

  assert_strobe_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_we || unsupported) |-> $past(exc_req));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .XLEN(XLEN), .RESET_VEC(RESET_VEC), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .pc(pc), .npc(npc),
  .status_in(status_in), .status_out(status_out), .status_we(status_we),
  .cause_out(cause_out), .cause_we(cause_we), .epc_out(epc_out),
  .epc_we(epc_we), .srsctl_we(srsctl_we), .redirect_pc(redirect_pc),
  .redirect_valid(redirect_valid), .unsupported(unsupported)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req;
  logic [4:0]  exc_kind;
  logic [31:0] pc, npc, status_in, cause_in, srsctl_in;
  logic [31:0] status_out, cause_out, epc_out, srsctl_out, redirect_pc;
  logic        status_we, cause_we, epc_we, srsctl_we, redirect_valid, unsupported;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;   // 50 MHz

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_kind(exc_kind),
    .pc(pc), .npc(npc), .status_in(status_in), .cause_in(cause_in),
    .srsctl_in(srsctl_in), .status_out(status_out), .status_we(status_we),
    .cause_out(cause_out), .cause_we(cause_we), .epc_out(epc_out),
    .epc_we(epc_we), .srsctl_out(srsctl_out), .srsctl_we(srsctl_we),
    .redirect_pc(redirect_pc), .redirect_valid(redirect_valid),
    .unsupported(unsupported)
  );

  typedef struct packed {
    logic        st_we, ca_we, epc_we, srs_we, redir, unsup;
    logic [31:0] st, ca, epc, srs, rpc;
  } exp_t;

  function automatic logic [4:0] code_of(input logic [4:0] k);
    case (k)
      5'd1:  return 5'd8;
      5'd2:  return 5'd9;
      5'd3:  return 5'd10;
      5'd4:  return 5'd11;
      5'd5:  return 5'd12;
      5'd6:  return 5'd13;
      5'd7:  return 5'd24;
      5'd11: return 5'd1;
      default: return 5'd0;
    endcase
  endfunction

  function automatic exp_t model(input logic req, input logic [4:0] k,
                                 input logic [31:0] p, np, st, ca, srs);
    exp_t e = '0;
    logic slot;
    if (!req) return e;
    slot = (np != p + 32'd4);
    if (k <= 5'd13) begin
      e.st_we = 1; e.ca_we = 1; e.epc_we = 1; e.redir = 1;
      e.st = st | 32'h0000_0002;
      e.ca = (ca & ~32'hB000_007C) | {27'd0, code_of(k), 2'b00} | {slot, 31'd0};
      e.epc = slot ? p - 32'd4 : p;
      e.srs_we = !st[1] && !st[22];
      e.srs = {srs[31:10], srs[3:0], srs[5:4], srs[15:12]};
      e.rpc = (st[22] ? 32'hBFC0_0200 : 32'h8000_0000) + ((k == 5'd0) ? 32'h0 : 32'h180);
    end else if (k == 5'd14) begin
      e.st_we = 1; e.redir = 1;
      e.st  = st | 32'h2000_0000;
      e.rpc = 32'hBFC0_0000;
    end else begin
      e.unsup = 1;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at a negedge, check at the next negedge (one register stage)
  task automatic apply(input string what, input logic req, input logic [4:0] k,
                       input logic [31:0] p, np, st, ca, srs);
    exp_t e;
    exc_req = req; exc_kind = k; pc = p; npc = np;
    status_in = st; cause_in = ca; srsctl_in = srs;
    e = model(req, k, p, np, st, ca, srs);
    @(negedge clk);
    chk("R9", what, {26'd0, status_we, cause_we, epc_we, srsctl_we, redirect_valid, unsupported},
        {26'd0, e.st_we, e.ca_we, e.epc_we, e.srs_we, e.redir, e.unsup});
    chk("R8", what, {31'd0, unsupported}, {31'd0, e.unsup});
    if (e.st_we)  chk(k == 5'd14 ? "R7" : "R2", what, status_out, e.st);
    if (e.ca_we)  chk("R5", what, cause_out, e.ca);
    if (e.epc_we) chk("R4", what, epc_out, e.epc);
    if (e.ca_we)  chk("R3", what, {31'd0, srsctl_we}, {31'd0, e.srs_we});
    if (e.srs_we) chk("R3", what, srsctl_out, e.srs);
    if (e.redir)  chk(k == 5'd14 ? "R7" : "R6", what, redirect_pc, e.rpc);
  endtask

  task automatic check_zero(input string what);
    chk("R1", what, {26'd0, status_we, cause_we, epc_we, srsctl_we, redirect_valid, unsupported}, 32'd0);
    chk("R1", what, status_out | cause_out | epc_out | srsctl_out | redirect_pc, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_unused;
    seed_unused = $urandom(32'd20240611);
    rst_n = 1'b0; exc_req = 1'b1; exc_kind = 5'd1; pc = 32'h100; npc = 32'h104;
    status_in = 0; cause_in = 0; srsctl_in = 32'h0000_5003;
    repeat (3) @(negedge clk);
    check_zero("request during reset");
    exc_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_zero("idle after release");

    // directed corners
    apply("syscall sequential", 1, 5'd1, 32'h0040_0010, 32'h0040_0014, 32'h0, 32'hFFFF_FFFF, 32'h0000_A005);
    apply("delay slot", 1, 5'd5, 32'h0040_0020, 32'h0040_1000, 32'h0, 32'h0, 32'h0000_F3C7);
    apply("exl already set", 1, 5'd6, 32'h0000_0200, 32'h0000_0204, 32'h0000_0002, 32'h3000_0000, 32'h0000_7001);
    apply("bev set", 1, 5'd7, 32'h0000_0300, 32'h0000_0304, 32'h0040_0000, 32'h0, 32'h0000_2001);
    apply("interrupt bev0", 1, 5'd0, 32'h0000_0400, 32'h0000_0408, 32'h0, 32'h0, 32'h0);
    apply("interrupt bev1", 1, 5'd0, 32'h0000_0400, 32'h0000_0404, 32'h0040_0000, 32'h0, 32'h0);
    apply("tlb modified", 1, 5'd11, 32'h0000_0500, 32'h0000_0504, 32'h0, 32'h0, 32'h0);
    apply("power-on kind", 1, 5'd14, 32'h1234_5678, 32'h0, 32'h0000_0001, 32'h0, 32'h0);
    apply("warm restart", 1, 5'd15, 32'h0, 32'h4, 32'h0, 32'h0, 32'h0);
    apply("non-maskable", 1, 5'd16, 32'h0, 32'h4, 32'h0, 32'h0, 32'h0);
    apply("undefined kind", 1, 5'd23, 32'h0, 32'h4, 32'h0, 32'h0, 32'h0);
    apply("idle", 0, 5'd1, 32'h0, 32'h4, 32'h0, 32'h0, 32'h0);
    apply("wrap pc zero slot", 1, 5'd3, 32'h0000_0000, 32'h0000_0010, 32'h0, 32'h0, 32'h0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] p, np, st;
      logic [4:0]  k;
      logic        rq;
      rq = ($urandom % 8) != 0;
      k  = ($urandom % 4 == 0) ? 5'($urandom % 32) : 5'($urandom % 17);
      p  = $urandom & 32'hFFFF_FFFC;
      np = ($urandom % 2 == 0) ? p + 32'd4 : ($urandom & 32'hFFFF_FFFC);
      st = $urandom;
      st[1]  = $urandom % 2;
      st[22] = $urandom % 2;
      apply("random", rq, k, p, np, st, $urandom, $urandom);
    end

    // reset in mid-run
    exc_req = 1'b1; exc_kind = 5'd2; rst_n = 1'b0;
    @(negedge clk);
    check_zero("mid-run reset");
    exc_req = 1'b0; rst_n = 1'b1;
    apply("after mid-run reset", 1, 5'd2, 32'h80, 32'h84, 32'h0, 32'h0, 32'h0000_1002);

    finish_run();
  end
endmodule